// File: doc/BRIEF.md
# Prescaled Interval Warning Timer

This block is a down-counting interval timer that warns software before a watchdog reset fires. A reference strobe, one bus-clock cycle wide for each cycle of the slow 32.768 kHz reference clock, drives an 8-bit prescaler. The prescaler produces one timer tick every (PRE+1) reference cycles. Each tick decrements a programmable count. When the count reaches zero, a sticky timeout status bit is set, and an interrupt is raised if the interrupt enable bit is set.

The run bit is stored as a request in the bus domain. It takes effect only at the next reference strobe, which stands in for the slow clock domain. The run bit reads back the value that has taken effect, not the value written. To reload the timer, software clears the run bit, polls until the read-back shows 0, writes a new count, and sets the run bit again. Count writes made while the timer is requested or running are dropped.

Top module: `warn_timer`

## Requirements
- R1: After reset, all registers read 0, the run read-back is 0 and `irq` is low.
- R2: Register map: address 0 is the prescaler (bits 7:0), address 1 is the count, and address 2 is control. Control bit 0 is run, bit 1 is interrupt enable and bit 2 is timeout status. Address 3 reads 0. Prescaler bits above 7 are discarded.
- R3: A write to the run bit is visible on control bit 0 only after the first reference strobe that follows the write. Until then the read-back keeps the old value.
- R4: While running, one tick occurs every (PRE+1) reference strobes. The prescaler is held at zero while the timer is stopped, so every start begins a full tick period.
- R5: Each tick decrements a nonzero count by one. With count N loaded, timeout status is set on exactly the N*(PRE+1)-th strobe after the strobe that started the timer.
- R6: After expiry the count stays at zero and is not reloaded. A run with a count of zero never sets the timeout status.
- R7: A count write is accepted only when both the requested and the effective run bits are 0. Otherwise the write is ignored.
- R8: Writing 1 to control bit 2 clears the timeout status and writing 0 leaves it unchanged. A new expiry in the same cycle as a clear wins over the clear.
- R9: `irq` is high exactly while the timeout status and the interrupt enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_pulse | input | 1 | One-cycle strobe per reference clock cycle |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| irq | output | 1 | Level interrupt: timeout status and interrupt enable |

## Verification
The hardest situation to reach is the window in which the run request and the effective run state disagree. During that window a count write must still be dropped, and the read-back must still show the old state. The bench drives the reference strobe itself, one strobe at a time, so it can write the run bit and then probe the count and the read-back before the next strobe arrives. The prescaler restart needs a stop part way through a tick period. The bench produces it by stopping after a known number of strobes and then measuring the full expiry time after the restart.

// File: rtl/wt_pkg.sv
// Package: shared register addresses and control bit positions for the
// interval warning timer. Assumes a 2-bit word address bus.
package wt_pkg;
    typedef enum logic [1:0] {
        WT_REG_PRE = 2'd0,
        WT_REG_CNT = 2'd1,
        WT_REG_CTL = 2'd2,
        WT_REG_NONE = 2'd3
    } wt_reg_e;

    localparam int CTL_RUN_BIT = 0;
    localparam int CTL_IE_BIT  = 1;
    localparam int CTL_TO_BIT  = 2;
endpackage

// File: rtl/wt_prescaler.sv
// Prescaler: counts reference strobes while the effective run state is set
// and emits one tick on every (pre_val+1)-th strobe. It is held at zero while
// stopped, so each start begins a full period. Assumes ref_pulse lasts one
// cycle.
module wt_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_act,
    input  logic             ref_pulse,
    input  logic [PRE_W-1:0] pre_val,
    output logic             tick
);
    logic [PRE_W-1:0] pre_cnt;

    // Terminal count reached on this strobe; >= covers a prescaler lowered mid-period.
    assign tick = run_act && ref_pulse && (pre_cnt >= pre_val);

    // Advance or wrap the strobe counter; hold at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_act) begin
            pre_cnt <= '0;
        end else if (ref_pulse) begin
            pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wt_counter.sv
// Down counter: loads on request, decrements once per tick while nonzero, and
// flags expiry on the step from one to zero. It never reloads by itself.
// Assumes load_en and tick are never high together (the register block only
// loads while the timer is stopped).
module wt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Expiry is the tick that takes the count from one to zero.
    assign expire = tick && (cnt == ONE);

    // Load or count down; saturate at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_en) begin
            cnt <= load_val;
        end else if (tick && (cnt != '0)) begin
            cnt <= cnt - ONE;
        end
    end
endmodule

// File: rtl/wt_regs.sv
// Register block: prescaler and control storage, the run request and its
// strobe-aligned effective copy, the sticky timeout status, and read muxing.
// Assumes ref_pulse marks the reference clock edge at which the run request
// takes effect.
module wt_regs
    import wt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_pulse,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              expire,
    output logic [PRE_W-1:0]  pre_val,
    output logic              load_en,
    output logic [CNT_W-1:0]  load_val,
    output logic              run_req,
    output logic              run_act,
    output logic              irq_en,
    output logic              status,
    output logic [DATA_W-1:0] bus_rdata
);
    logic wr_pre, wr_cnt, wr_ctl;

    // Decode write targets.
    assign wr_pre = bus_sel && bus_wr && (wt_reg_e'(bus_addr) == WT_REG_PRE);
    assign wr_cnt = bus_sel && bus_wr && (wt_reg_e'(bus_addr) == WT_REG_CNT);
    assign wr_ctl = bus_sel && bus_wr && (wt_reg_e'(bus_addr) == WT_REG_CTL);

    // Count load only when the timer is stopped both as requested and in effect.
    assign load_en  = wr_cnt && !run_req && !run_act;
    assign load_val = bus_wdata[CNT_W-1:0];

    // Prescaler, run request and interrupt enable storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_val <= '0;
            run_req <= 1'b0;
            irq_en  <= 1'b0;
        end else begin
            if (wr_pre) pre_val <= bus_wdata[PRE_W-1:0];
            if (wr_ctl) begin
                run_req <= bus_wdata[CTL_RUN_BIT];
                irq_en  <= bus_wdata[CTL_IE_BIT];
            end
        end
    end

    // Run request takes effect at the reference strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_act <= 1'b0;
        end else if (ref_pulse) begin
            run_act <= run_req;
        end
    end

    // Sticky timeout status: expiry sets, write-one clears, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= 1'b0;
        end else if (expire) begin
            status <= 1'b1;
        end else if (wr_ctl && bus_wdata[CTL_TO_BIT]) begin
            status <= 1'b0;
        end
    end

    // Read mux; run bit shows the effective state.
    always_comb begin
        bus_rdata = '0;
        case (wt_reg_e'(bus_addr))
            WT_REG_PRE: bus_rdata = DATA_W'(pre_val);
            WT_REG_CNT: bus_rdata = DATA_W'(cnt_val);
            WT_REG_CTL: begin
                bus_rdata[CTL_RUN_BIT] = run_act;
                bus_rdata[CTL_IE_BIT]  = irq_en;
                bus_rdata[CTL_TO_BIT]  = status;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/warn_timer.sv
// Top: interval warning timer. Connects the register block, prescaler and
// down counter, and drives the level interrupt. Assumes CNT_W <= DATA_W,
// PRE_W <= DATA_W and DATA_W >= 3.
module warn_timer #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_pulse,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [PRE_W-1:0] pre_val;
    logic [CNT_W-1:0] load_val, cnt;
    logic load_en, run_req, run_act, irq_en, status, tick, expire;

    wt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PRE_W(PRE_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cnt_val(cnt), .expire(expire),
        .pre_val(pre_val), .load_en(load_en), .load_val(load_val),
        .run_req(run_req), .run_act(run_act), .irq_en(irq_en),
        .status(status), .bus_rdata(bus_rdata)
    );

    wt_prescaler #(.PRE_W(PRE_W)) pre_i (
        .clk(clk), .rst_n(rst_n), .run_act(run_act),
        .ref_pulse(ref_pulse), .pre_val(pre_val), .tick(tick)
    );

    wt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
        .tick(tick), .cnt(cnt), .expire(expire)
    );

    // Level interrupt gated by the enable bit.
    assign irq = status && irq_en;
endmodule

// File: rtl/warn_timer_chk.sv
// Checker: temporal properties of the warning timer, bound into the top.
module warn_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_pulse,
    input logic             run_act,
    input logic             irq_en,
    input logic             status,
    input logic             tick,
    input logic             irq,
    input logic [CNT_W-1:0] cnt
);
    // R3
    run_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_act != $past(run_act)) |-> $past(ref_pulse));

    // R4
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (run_act && ref_pulse));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

    // R5
    expire_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> (cnt == '0));

    // R6
    zero_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_act && cnt == '0) |=> (cnt == '0));

    // R7
    no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_act |=> (cnt <= $past(cnt)));

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en || !status) |-> !irq);
endmodule

bind warn_timer warn_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .run_act(run_act),
    .irq_en(irq_en), .status(status), .tick(tick), .irq(irq), .cnt(cnt)
);

// File: tb/warn_timer_tb_top.sv
// Bench: drives reference strobes one at a time and sweeps prescaler and
// count values, computing expiry times arithmetically.
module warn_timer_tb_top;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_pulse = 1'b0;
    logic bus_sel = 1'b0;
    logic bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    warn_timer dut_i (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = DW'(d);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        @(negedge clk);
        bus_addr = a;
        #1 d = int'(bus_rdata);
    endtask

    task automatic pulse();
        @(negedge clk);
        ref_pulse = 1'b1;
        @(negedge clk);
        ref_pulse = 1'b0;
    endtask

    // Stop, apply the stop at a strobe, and clear any status.
    task automatic stop_clear();
        wr(2'd2, 0);
        pulse();
        wr(2'd2, 4);
    endtask

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
                $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int v;
        int first;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); chk("R1 pre", v, 0);
        rd(2'd1, v); chk("R1 cnt", v, 0);
        rd(2'd2, v); chk("R1 ctl", v, 0);
        chk("R1 irq", int'(irq), 0);

        // R2 map and prescaler width
        wr(2'd0, 16'h1AB);
        rd(2'd0, v); chk("R2 pre width", v, 16'hAB);
        rd(2'd3, v); chk("R2 addr3", v, 0);

        // R4 R5 sweep
        for (int pre = 0; pre < 4; pre++) begin
            for (int ni = 0; ni < 4; ni++) begin
                int n;
                int exp;
                n = (ni == 3) ? 5 : ni + 1;
                exp = n * (pre + 1);
                stop_clear();
                wr(2'd0, pre);
                wr(2'd1, n);
                rd(2'd1, v); chk("R7 load stopped", v, n);
                wr(2'd2, 3);
                rd(2'd2, v); chk("R3 lag", v & 1, 0);
                pulse();
                rd(2'd2, v); chk("R3 effect", v & 1, 1);
                first = -1;
                for (int k = 1; k <= exp + 2; k++) begin
                    pulse();
                    rd(2'd2, v);
                    if (first < 0 && (v & 4) != 0) first = k;
                end
                chk("R5 expiry strobe", first, exp);
                chk("R9 irq set", int'(irq), 1);
            end
        end

        // R6 no reload after expiry (timer still running, pre=3)
        for (int k = 0; k < 12; k++) pulse();
        rd(2'd1, v); chk("R6 stays zero", v, 0);
        rd(2'd2, v); chk("R6 status kept", (v >> 2) & 1, 1);

        // R7 write while running ignored
        wr(2'd1, 7);
        rd(2'd1, v); chk("R7 running write", v, 0);

        // R8 write 0 keeps, write 1 clears
        wr(2'd2, 3);
        rd(2'd2, v); chk("R8 write0", (v >> 2) & 1, 1);
        // R9 enable low masks irq
        wr(2'd2, 1);
        chk("R9 masked", int'(irq), 0);
        wr(2'd2, 3);
        chk("R9 unmasked", int'(irq), 1);
        wr(2'd2, 7);
        rd(2'd2, v); chk("R8 clear", (v >> 2) & 1, 0);
        chk("R9 irq low", int'(irq), 0);

        // R7 stop requested but not effective: still ignored
        wr(2'd2, 0);
        wr(2'd1, 9);
        rd(2'd1, v); chk("R7 pending stop", v, 0);
        rd(2'd2, v); chk("R3 still running", v & 1, 1);
        pulse();
        rd(2'd2, v); chk("R3 stopped", v & 1, 0);
        wr(2'd1, 9);
        rd(2'd1, v); chk("R7 accepted", v, 9);

        // R4 prescaler restarts from zero after stop mid-period
        stop_clear();
        wr(2'd0, 3);
        wr(2'd1, 1);
        wr(2'd2, 1);
        pulse();
        pulse(); pulse();
        wr(2'd2, 0);
        pulse();
        wr(2'd2, 1);
        pulse();
        first = -1;
        for (int k = 1; k <= 8; k++) begin
            pulse();
            rd(2'd2, v);
            if (first < 0 && (v & 4) != 0) first = k;
        end
        chk("R4 restart period", first, 4);

        // R6 zero count never expires
        stop_clear();
        wr(2'd0, 0);
        wr(2'd1, 0);
        wr(2'd2, 3);
        for (int k = 0; k < 10; k++) pulse();
        rd(2'd2, v); chk("R6 zero count", (v >> 2) & 1, 0);
        chk("R9 zero count irq", int'(irq), 0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule